// File: doc/BRIEF.md
# Fixed-Priority Central Bus Arbiter

This block decides which of several masters on a shared bus is allowed to own it next. Each master raises its own request line and receives its own grant line. The arbiter always points its grant at the highest-priority master that is currently requesting. That master is the master-elect. The current owner may still be holding the bus busy at that point, so the choice of the next owner is made while the present transfer is still running.

A grant is not final until the elect has taken the bus. If a more important master starts requesting while the bus is still busy, the grant moves to it at the next clock edge. Taking a grant away from a master is also the arbiter's way of telling the present owner to leave the bus. A shared lock line lets an owner keep its grant through an indivisible sequence of accesses. Priority is fixed: a lower index wins. All grant changes are registered, so the grant lines change one clock after the inputs that caused the change.

Top module: `prio_bus_arbiter`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, every bit of `grant` is 0.
- R2: At no clock cycle is more than one bit of `grant` set.
- R3: With `bus_lock` low, on the clock edge after `req` is sampled, `grant` is one-hot at the lowest-numbered set bit of `req`. Index 0 has the highest priority.
- R4: If `req` is all zeros and no locked grant is being held, `grant` becomes all zeros on the next edge.
- R5: While `bus_busy` is high, a newly requesting master of higher priority than the current grant holder takes the grant on the next edge. The old grant bit falls and the new one rises on that same edge.
- R6: A grant is withdrawn from its holder on the next edge when the holder drops its request, or when a higher-priority request appears, even while `bus_busy` is low.
- R7: While `bus_lock` is high and a grant is active, `grant` keeps its value, whatever `req` does.
- R8: `bus_lock` high while no grant is active has no effect: arbitration proceeds as in R3.
- R9: `bus_busy` has no effect on which master is granted. The same `req` sequence yields the same `grant` sequence for any `bus_busy` pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, applied synchronously |
| req | input | NUM_MASTERS | One request bit per master, bit 0 highest priority |
| bus_busy | input | 1 | Shared line: the current owner is still using the bus |
| bus_lock | input | 1 | Shared line: the owner must not be displaced |
| grant | output | NUM_MASTERS | One grant bit per master, at most one set |

## Verification
Every grant result is due exactly one rising edge after the inputs that cause it. Inputs are driven on the falling edge. The expected grant is computed at that moment and put in a queue. A monitor removes it from the queue and compares it 2 ns after the following rising edge, so each comparison lands in the single cycle where the result belongs. The reset value is compared while reset is still held. The lock cases rely on the bench's own record of the previous grant, which it keeps from one stimulus to the next.

// File: rtl/prio_bus_arbiter_pkg.sv
package prio_bus_arbiter_pkg;
  typedef enum logic [1:0] {
    DEC_IDLE = 2'd0,
    DEC_PICK = 2'd1,
    DEC_HOLD = 2'd2
  } arb_dec_e;
endpackage

// File: rtl/prio_bus_arbiter_pick.sv
module prio_bus_arbiter_pick #(
  parameter int NUM_MASTERS = 4
) (
  input  logic [NUM_MASTERS-1:0] req,
  output logic [NUM_MASTERS-1:0] winner,
  output logic                   any_req
);
  logic [NUM_MASTERS:0] seen;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_chain
    assign winner[i]  = req[i] & ~seen[i];
    assign seen[i+1]  = seen[i] | req[i];
  end

  assign any_req = seen[NUM_MASTERS];
endmodule

// File: rtl/prio_bus_arbiter_ctrl.sv
module prio_bus_arbiter_ctrl
  import prio_bus_arbiter_pkg::*;
#(
  parameter int NUM_MASTERS = 4
) (
  input  logic [NUM_MASTERS-1:0] winner,
  input  logic                   any_req,
  input  logic [NUM_MASTERS-1:0] grant_q,
  input  logic                   bus_lock,
  output arb_dec_e               decision,
  output logic [NUM_MASTERS-1:0] grant_d
);
  function automatic arb_dec_e decide(input logic lock, input logic held, input logic pending);
    if (lock && held) return DEC_HOLD;
    if (pending)      return DEC_PICK;
    return DEC_IDLE;
  endfunction

  assign decision = decide(bus_lock, |grant_q, any_req);

  always_comb begin
    unique case (decision)
      DEC_HOLD: grant_d = grant_q;
      DEC_PICK: grant_d = winner;
      default:  grant_d = '0;
    endcase
  end
endmodule

// File: rtl/prio_bus_arbiter_grant_reg.sv
module prio_bus_arbiter_grant_reg #(
  parameter int NUM_MASTERS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_MASTERS-1:0] grant_d,
  output logic [NUM_MASTERS-1:0] grant_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) grant_q <= '0;
    else        grant_q <= grant_d;
  end
endmodule

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter
  import prio_bus_arbiter_pkg::*;
#(
  parameter int NUM_MASTERS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_MASTERS-1:0] req,
  input  logic                   bus_busy,
  input  logic                   bus_lock,
  output logic [NUM_MASTERS-1:0] grant
);
  logic [NUM_MASTERS-1:0] winner;
  logic [NUM_MASTERS-1:0] grant_d;
  logic [NUM_MASTERS-1:0] grant_q;
  logic                   any_req;
  arb_dec_e               decision;

  // Named events, brought out for the checker
  logic ev_move;
  logic ev_hold;
  logic ev_elect_swap;

  prio_bus_arbiter_pick #(.NUM_MASTERS(NUM_MASTERS)) u_pick (
    .req     (req),
    .winner  (winner),
    .any_req (any_req)
  );

  prio_bus_arbiter_ctrl #(.NUM_MASTERS(NUM_MASTERS)) u_ctrl (
    .winner   (winner),
    .any_req  (any_req),
    .grant_q  (grant_q),
    .bus_lock (bus_lock),
    .decision (decision),
    .grant_d  (grant_d)
  );

  prio_bus_arbiter_grant_reg #(.NUM_MASTERS(NUM_MASTERS)) u_greg (
    .clk     (clk),
    .rst_n   (rst_n),
    .grant_d (grant_d),
    .grant_q (grant_q)
  );

  assign ev_move       = (|grant_q) && (|grant_d) && (grant_d != grant_q);
  assign ev_hold       = (decision == DEC_HOLD);
  assign ev_elect_swap = ev_move && bus_busy;

  assign grant = grant_q;
endmodule

// File: rtl/prio_bus_arbiter_chk.sv
module prio_bus_arbiter_chk #(
  parameter int NUM_MASTERS = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_MASTERS-1:0] req,
  input logic                   bus_lock,
  input logic [NUM_MASTERS-1:0] grant,
  input logic                   ev_move,
  input logic                   ev_hold,
  input logic                   ev_elect_swap
);
  p_single_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_top_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req[0] && !(bus_lock && |grant)) |=> grant[0]);

  p_idle_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|req) && !(bus_lock && |grant)) |=> (grant == '0));

  p_swap_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_elect_swap |=> ($countones(grant) == 1 && grant != $past(grant)));

  p_move_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_move |=> ($countones(grant) == 1));

  p_lock_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hold |=> $stable(grant));

  for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_src
    p_grant_has_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grant[i]) |-> ($past(req[i]) && !$past(bus_lock && |grant)));
  end
endmodule

bind prio_bus_arbiter prio_bus_arbiter_chk #(.NUM_MASTERS(NUM_MASTERS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req           (req),
  .bus_lock      (bus_lock),
  .grant         (grant),
  .ev_move       (ev_move),
  .ev_hold       (ev_hold),
  .ev_elect_swap (ev_elect_swap)
);

// File: tb/prio_bus_arbiter_tb_top.sv
`timescale 1ns/1ps
module prio_bus_arbiter_tb_top;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic         bus_busy = 1'b0;
  logic         bus_lock = 1'b0;
  logic [N-1:0] grant;

  typedef struct {
    logic [N-1:0] exp;
    string        tag;
  } item_t;

  item_t        sb_q[$];
  int           n_cmp = 0;
  int           n_bad = 0;
  logic [N-1:0] model_g = '0;
  logic         done = 1'b0;

  always #5 clk = ~clk;

  prio_bus_arbiter #(.NUM_MASTERS(N)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .bus_busy (bus_busy),
    .bus_lock (bus_lock),
    .grant    (grant)
  );

  // Reference: scan from the lowest priority upward, the last hit wins
  function automatic logic [N-1:0] ref_pick(input logic [N-1:0] r);
    logic [N-1:0] o = '0;
    for (int k = N - 1; k >= 0; k--)
      if (r[k]) o = ({{(N-1){1'b0}}, 1'b1} << k);
    return o;
  endfunction

  task automatic check(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: grant actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [N-1:0] r, input logic busy, input logic lock, input string tag);
    item_t it;
    @(negedge clk);
    req      = r;
    bus_busy = busy;
    bus_lock = lock;
    if (lock && (model_g != '0)) it.exp = model_g;
    else                         it.exp = ref_pick(r);
    model_g = it.exp;
    it.tag  = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: each result is due one rising edge after its stimulus
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(grant, it.exp, it.tag);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    req = 4'b0101;
    @(negedge clk);
    check(grant, '0, "R1 reset held");
    req = '0;
    rst_n = 1'b1;
    #3;
    check(grant, '0, "R1 first cycle after reset");

    drive(4'b0100, 1'b0, 1'b0, "R3 single requester");
    drive(4'b0110, 1'b1, 1'b0, "R5 higher newcomer while busy");
    drive(4'b0111, 1'b1, 1'b0, "R5 top newcomer while busy");
    drive(4'b0000, 1'b0, 1'b0, "R4 all requests gone");
    drive(4'b1000, 1'b0, 1'b0, "R3 lowest priority alone");
    drive(4'b1001, 1'b0, 1'b0, "R6 owner displaced, bus idle");
    drive(4'b1000, 1'b0, 1'b0, "R6 holder dropped request");
    drive(4'b0100, 1'b1, 1'b1, "R7 hold under lock, new request");
    drive(4'b0001, 1'b1, 1'b1, "R7 hold under lock, top request");
    drive(4'b0000, 1'b1, 1'b1, "R7 hold under lock, no request");
    drive(4'b0000, 1'b0, 1'b0, "R4 lock released, idle");
    drive(4'b0010, 1'b0, 1'b1, "R8 lock without grant");
    drive(4'b1010, 1'b1, 1'b0, "R9 busy high same winner");
    drive(4'b1010, 1'b0, 1'b0, "R9 busy low same winner");
    drive(4'b1110, 1'b1, 1'b0, "R9 busy high extra lower req");

    for (int s = 0; s < 300; s++) begin
      logic [N-1:0] r;
      r = N'($urandom);
      drive(r, 1'($urandom), ($urandom % 4) == 0, "R3 random sweep");
    end
    drive('0, 1'b0, 1'b0, "R4 final idle");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule